// File: doc/BRIEF.md
# Synchronization Status Tracker

This block follows the clock-synchronization status of an end system on a time-scheduled Ethernet network. A separate frame parser gives it a one-cycle pulse for each valid integration frame from the compression master. A round timer pulses at the end of each synchronization round. A watchdog pulses when no master has been heard for too long. The transmit path pulses once its coldstart frame has gone out. From these events the block chooses one of four live states and reports it as a 3-bit code. While it is in the coldstart state it requests that a coldstart frame be sent.

When a valid integration frame arrives while the node is synchronized, the block loads the local clock. The value is the frame's receive timestamp minus the residence delay that the switches on the path added to the frame. The block gives a one-cycle load strobe with this corrected value.

The state changes are deliberately uneven. The node needs three good rounds in a row to become stable. One bad round takes it back out of stable. Only five bad rounds in a row make it give up synchronization.

Top module: `sync_status_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state becomes 0 (unsynchronized), and `coldstart_req_o` and `clk_load_o` become 0.
- R2: In state 0, a `frame_ok_i` pulse sets the state to 2 (synchronized) at the next edge. It takes priority over a `master_timeout_i` pulse in the same cycle.
- R3: A round is good if `frame_ok_i` was high in any cycle since the previous `round_end_i`, counting the cycle of the `round_end_i` itself. In state 2, the third consecutive good round sets the state to 3 (stable) at the edge where that round ends.
- R4: In state 2, the fifth consecutive missed round sets the state to 0. A good round in between restarts the miss count from zero.
- R5: In state 3, a single missed round sets the state to 2. Three new consecutive good rounds are then needed to reach state 3 again.
- R6: In state 0, `master_timeout_i` without `frame_ok_i` sets the state to 4 (coldstart). `coldstart_req_o` is 1 exactly while the state is 4.
- R7: In state 4, either `coldstart_done_i` or `frame_ok_i` sets the state to 2 at the next edge.
- R8: Every change of state clears the round counters and opens a new round. The frame that moves the node into state 2 does not count toward the first round.
- R9: A `frame_ok_i` pulse in state 2 or 3 makes `clk_load_o` high for exactly one cycle, one edge later. `clk_value_o` then equals `rx_time_i - resid_i` as sampled with the pulse, taken modulo 2^TW. A pulse in state 0 or 4 gives no load.
- R10: `round_end_i` has no effect in states 0 and 4. `master_timeout_i` has no effect outside state 0. The state code 1 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_ok_i | input | 1 | Valid integration frame received (pulse) |
| round_end_i | input | 1 | End of a synchronization round (pulse) |
| master_timeout_i | input | 1 | No master heard within the timeout (pulse) |
| coldstart_done_i | input | 1 | Coldstart frame has been sent (pulse) |
| rx_time_i | input | TW | Receive timestamp of the frame |
| resid_i | input | TW | Residence delay accumulated along the path |
| state_o | output | 3 | Sync state: 0 unsync, 2 sync, 3 stable, 4 coldstart |
| coldstart_req_o | output | 1 | Request to transmit a coldstart frame |
| clk_load_o | output | 1 | Local clock load strobe |
| clk_value_o | output | TW | Corrected time to load |

## Verification
A frame pulse and a round-end pulse can occur in the same cycle. The frame must then count toward the round that is closing, and the same frame must also load the clock. The bench closes rounds in two ways: with a frame exactly on the round-end cycle, and with a frame earlier in the round. For each, it checks the state code after the round ends and the load strobe with its corrected value. It also sends a frame together with a round end in the stable state and expects no demotion. And it sends a frame together with a timeout in the unsynchronized state and expects the node to enter state 2, not coldstart.

// File: rtl/sync_status_pkg.sv
// Shared state type for the synchronization status tracker.
// Assumes the encodings are fixed and decoded by neighbours.
package sync_status_pkg;
    typedef enum logic [2:0] {
        ST_UNSYNC = 3'd0,
        ST_INTEG  = 3'd1,
        ST_SYNC   = 3'd2,
        ST_STABLE = 3'd3,
        ST_COLD   = 3'd4
    } sync_state_e;
endpackage

// File: rtl/sync_round_monitor.sv
// Judges each round as good or missed and counts consecutive outcomes.
// Assumes count_en is high only in the synchronized state. clr_i clears
// the counters and the round latch whenever the state changes.
module sync_round_monitor #(
    parameter int GOOD_N = 3,
    parameter int MISS_N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_ok_i,
    input  logic round_end_i,
    input  logic count_en_i,
    input  logic clr_i,
    output logic good_hit_o,
    output logic miss_hit_o,
    output logic miss_now_o
);
    localparam int MAXN = (GOOD_N > MISS_N) ? GOOD_N : MISS_N;
    localparam int CW   = $clog2(MAXN + 1);

    logic          seen_q;
    logic [CW-1:0] good_q, miss_q;
    logic          good_round;

    // A round is good if a frame arrived in it, including its closing cycle.
    assign good_round = seen_q | frame_ok_i;
    assign miss_now_o = round_end_i & ~good_round;
    assign good_hit_o = count_en_i & round_end_i & good_round & (good_q == CW'(GOOD_N - 1));
    assign miss_hit_o = count_en_i & miss_now_o & (miss_q == CW'(MISS_N - 1));

    // Latch frame arrival within the current round.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || round_end_i) seen_q <= 1'b0;
        else if (frame_ok_i)                seen_q <= 1'b1;
    end

    // Count consecutive good and missed rounds; each outcome clears the other.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            good_q <= '0;
            miss_q <= '0;
        end else if (count_en_i && round_end_i) begin
            if (good_round) begin
                good_q <= good_q + 1'b1;
                miss_q <= '0;
            end else begin
                miss_q <= miss_q + 1'b1;
                good_q <= '0;
            end
        end
    end

    a_r3_good_bound: assert property (@(posedge clk) disable iff (!rst_n)
        good_q < CW'(GOOD_N));
    a_r4_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q < CW'(MISS_N));
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (good_q == '0 && miss_q == '0 && !seen_q));
endmodule

// File: rtl/sync_time_corrector.sv
// Forms the corrected cluster time (receive time minus residence delay)
// and registers it with a one-cycle load strobe.
// Assumes take_i is a one-cycle pulse qualified by the sync state.
module sync_time_corrector #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [TW-1:0] rx_time_i,
    input  logic [TW-1:0] resid_i,
    output logic          load_o,
    output logic [TW-1:0] value_o
);
    // Register the strobe and the corrected time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o  <= 1'b0;
            value_o <= '0;
        end else begin
            load_o <= take_i;
            if (take_i) value_o <= rx_time_i - resid_i;
        end
    end

    a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (load_o == $past(take_i)));
    a_r9_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (value_o + $past(resid_i) == $past(rx_time_i)));
endmodule

// File: rtl/sync_state_fsm.sv
// Synchronization state register and next-state logic.
// Assumes the round verdicts come from sync_round_monitor in the same cycle.
module sync_state_fsm
    import sync_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_ok_i,
    input  logic        master_timeout_i,
    input  logic        coldstart_done_i,
    input  logic        good_hit_i,
    input  logic        miss_hit_i,
    input  logic        miss_now_i,
    output sync_state_e state_o,
    output logic        change_o
);
    sync_state_e nxt;

    // Pick the next state from the current state and this cycle's events.
    always_comb begin
        nxt = state_o;
        case (state_o)
            ST_UNSYNC: if (frame_ok_i) nxt = ST_SYNC;
                       else if (master_timeout_i) nxt = ST_COLD;
            ST_COLD:   if (frame_ok_i || coldstart_done_i) nxt = ST_SYNC;
            ST_SYNC:   if (good_hit_i) nxt = ST_STABLE;
                       else if (miss_hit_i) nxt = ST_UNSYNC;
            ST_STABLE: if (miss_now_i) nxt = ST_SYNC;
            default:   nxt = ST_UNSYNC;
        endcase
    end

    assign change_o = (nxt != state_o);

    // Hold the state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_UNSYNC;
        else        state_o <= nxt;
    end

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> state_o == ST_UNSYNC);
    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_UNSYNC && frame_ok_i) |=> state_o == ST_SYNC);
    a_r5_demote: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_STABLE && miss_now_i) |=> state_o == ST_SYNC);
    a_r7_cold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_COLD && coldstart_done_i) |=> state_o == ST_SYNC);
    a_r3_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_UNSYNC || state_o == ST_COLD) |=> state_o != ST_STABLE);
endmodule

// File: rtl/sync_status_tracker.sv
// Top level: tracks end-system sync status and loads the corrected clock.
// Assumes all event inputs are single-cycle pulses in the clk domain.
module sync_status_tracker
    import sync_status_pkg::*;
#(
    parameter int TW     = 32,
    parameter int GOOD_N = 3,
    parameter int MISS_N = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_ok_i,
    input  logic          round_end_i,
    input  logic          master_timeout_i,
    input  logic          coldstart_done_i,
    input  logic [TW-1:0] rx_time_i,
    input  logic [TW-1:0] resid_i,
    output logic [2:0]    state_o,
    output logic          coldstart_req_o,
    output logic          clk_load_o,
    output logic [TW-1:0] clk_value_o
);
    sync_state_e st;
    logic good_hit, miss_hit, miss_now, change, count_en, take;

    assign count_en        = (st == ST_SYNC);
    assign take            = frame_ok_i & (st == ST_SYNC || st == ST_STABLE);
    assign state_o         = st;
    assign coldstart_req_o = (st == ST_COLD);

    sync_round_monitor #(.GOOD_N(GOOD_N), .MISS_N(MISS_N)) u_mon (
        .clk(clk), .rst_n(rst_n), .frame_ok_i(frame_ok_i),
        .round_end_i(round_end_i), .count_en_i(count_en), .clr_i(change),
        .good_hit_o(good_hit), .miss_hit_o(miss_hit), .miss_now_o(miss_now)
    );

    sync_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_ok_i(frame_ok_i),
        .master_timeout_i(master_timeout_i), .coldstart_done_i(coldstart_done_i),
        .good_hit_i(good_hit), .miss_hit_i(miss_hit), .miss_now_i(miss_now),
        .state_o(st), .change_o(change)
    );

    sync_time_corrector #(.TW(TW)) u_corr (
        .clk(clk), .rst_n(rst_n), .take_i(take), .rx_time_i(rx_time_i),
        .resid_i(resid_i), .load_o(clk_load_o), .value_o(clk_value_o)
    );

    a_r10_no_code1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 3'd1);
    a_r6_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && master_timeout_i && !frame_ok_i) |=> coldstart_req_o);
endmodule

// File: tb/test_sync_status_tracker.sv
`timescale 1ns/1ps
module test_sync_status_tracker;
    localparam int TW = 32;
    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_ok = 0, round_end = 0, tmo = 0, cs_done = 0;
    logic [TW-1:0] rx_time = '0, resid = '0;
    logic [2:0] state;
    logic cs_req, ld;
    logic [TW-1:0] val;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sync_status_tracker #(.TW(TW), .GOOD_N(3), .MISS_N(5)) i_sync_status_tracker (
        .clk(clk), .rst_n(rst_n), .frame_ok_i(frame_ok), .round_end_i(round_end),
        .master_timeout_i(tmo), .coldstart_done_i(cs_done), .rx_time_i(rx_time),
        .resid_i(resid), .state_o(state), .coldstart_req_o(cs_req),
        .clk_load_o(ld), .clk_value_o(val)
    );

    task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, sample 1 ns after the edge, then clear.
    task automatic step(logic f, logic re, logic to, logic cd);
        frame_ok = f; round_end = re; tmo = to; cs_done = cd;
        @(posedge clk); #1;
        frame_ok = 0; round_end = 0; tmo = 0; cs_done = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; step(0, 0, 0, 0); step(0, 0, 0, 0); rst_n = 1;
    endtask

    // Good round: frame on the closing cycle or earlier in the round.
    task automatic good_round(bit same_cycle);
        if (same_cycle) step(1, 1, 0, 0);
        else begin step(1, 0, 0, 0); step(0, 0, 0, 0); step(0, 1, 0, 0); end
    endtask

    task automatic miss_round();
        step(0, 0, 0, 0); step(0, 1, 0, 0);
    endtask

    task automatic to_sync();
        do_reset(); step(1, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        frame_ok = 1; rx_time = 5;
        rst_n = 0; @(posedge clk); #1; @(posedge clk); #1;
        check("R1 state", state, 0);
        check("R1 req", cs_req, 0);
        check("R1 load", ld, 0);
        frame_ok = 0; rst_n = 1;

        // R10 round_end ignored in UNSYNC
        step(0, 1, 0, 0);
        check("R10 unsync round_end", state, 0);
        // R2 frame beats timeout; R8 entry frame does not load (state 0)
        step(1, 0, 1, 0);
        check("R2 enter sync", state, 2);
        check("R9 no load from unsync", ld, 0);

        // R3/R8 sweep: good rounds counted from entry, both coincidence styles
        for (int sc = 0; sc < 2; sc++) begin
            to_sync();
            for (int g = 1; g <= 3; g++) begin
                good_round(sc == 1);
                check($sformatf("R3 good=%0d sc=%0d", g, sc), state, (g == 3) ? 3 : 2);
            end
        end

        // R10 timeout ignored in STABLE; frame on round end keeps STABLE
        step(0, 0, 1, 0);
        check("R10 timeout in stable", state, 3);
        step(1, 1, 0, 0);
        check("R5 frame on round end", state, 3);

        // R5 single miss demotes, then three goods needed again
        miss_round();
        check("R5 demote", state, 2);
        good_round(1); good_round(0);
        check("R5 two goods not enough", state, 2);
        good_round(1);
        check("R5 re-stable", state, 3);

        // R4 sweep: m consecutive misses in SYNC
        for (int m = 1; m <= 5; m++) begin
            to_sync();
            for (int k = 0; k < m; k++) miss_round();
            check($sformatf("R4 misses=%0d", m), state, (m == 5) ? 0 : 2);
        end
        // R4 interrupted count
        to_sync();
        for (int k = 0; k < 4; k++) miss_round();
        good_round(1);
        for (int k = 0; k < 4; k++) miss_round();
        check("R4 restart after good", state, 2);
        miss_round();
        check("R4 fifth miss", state, 0);

        // R6 coldstart path, R10 ignored events, R7 exits
        for (int ex = 0; ex < 2; ex++) begin
            do_reset();
            step(0, 0, 1, 0);
            check("R6 cold state", state, 4);
            check("R6 req high", cs_req, 1);
            step(0, 1, 1, 0);
            check("R10 cold ignores", state, 4);
            if (ex == 0) step(0, 0, 0, 1); else step(1, 0, 0, 0);
            check($sformatf("R7 exit %0d", ex), state, 2);
            check("R6 req low", cs_req, 0);
            check("R9 no load from cold", ld, 0);
        end

        // R9 correction sweep including wrap-around
        to_sync();
        for (int i = 0; i < 8; i++) begin
            logic [TW-1:0] r, d;
            r = 32'h1000_0000 * i + 77 * i;
            d = 32'h0300_0010 * (i + 1);
            rx_time = r; resid = d;
            step(1, 0, 0, 0);
            check($sformatf("R9 load i=%0d", i), ld, 1);
            check($sformatf("R9 value i=%0d", i), val, r - d);
            step(0, 0, 0, 0);
            check($sformatf("R9 one cycle i=%0d", i), ld, 0);
        end
        // R9 load in STABLE
        good_round(1); good_round(1);
        rx_time = 1000; resid = 30;
        good_round(1);
        check("R9 stable state", state, 3);
        check("R9 load on round end", ld, 1);
        check("R9 value on round end", val, 970);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule